// File: doc/BRIEF.md
# Wake-up Frame Pattern Filter

This block watches one received Ethernet frame at a time, delivered as a byte stream with start, valid and end strobes, and decides whether that frame is the wake-up frame that software has programmed. A window of up to 31 bytes begins at a programmable offset. A selection mask picks which bytes of that window feed a CRC-16. When the frame ends, the CRC is compared with a programmed value. The frame also has to carry the programmed destination address kind, unicast or multicast. A successful comparison produces a single-cycle pulse.

The control is a two-state machine. `ST_IDLE` waits for a start strobe. The transition *open* (start byte without end) moves it to `ST_RECV`. In `ST_RECV` the transition *close* (end byte) returns it to `ST_IDLE`, and *restart* (a fresh start byte) stays in `ST_RECV` and begins a new frame. A start byte that is also the end byte is the transition *single*, which stays in `ST_IDLE`. A byte counter, a CRC accumulator and a destination-class latch sit beside the machine. The configuration inputs are expected to come straight from registers elsewhere in the chip.

Top module: `wake_pattern_filter`

## Requirements
- R1: The byte with index `eff_ofs + j` (index 0 is the start byte), with j from 0 to 30, enters the CRC exactly when `pat_mask[j]` is 1. Every other byte is skipped.
- R2: `pat_mask[31]` has no effect. No 32nd window byte is ever included.
- R3: The CRC-16 uses polynomial 0x8005, starts at 0xFFFF and takes each byte least significant bit first. It restarts at every start byte, so no earlier frame influences the result.
- R4: The effective offset `eff_ofs` is `pat_offset` when that is 12 or more, and 12 otherwise.
- R5: When `pat_cmd[0]` (enable) is 0, `wake_hit` stays 0.
- R6: A frame is multicast when bit 0 of its start byte is 1. When `pat_cmd[3]` is 1 only multicast frames can hit, and when it is 0 only unicast frames can. `pat_cmd[2:1]` have no effect.
- R7: A hit needs the final CRC to equal `pat_crc`. Any difference suppresses it.
- R8: `wake_hit` is high for exactly one cycle, in the cycle after the end byte is accepted, and is never high at any other time.
- R9: A frame that ends before its window is complete is still compared, using the selected bytes received so far.
- R10: The byte counter saturates, so bytes far beyond the window in a long frame never wrap back into it.
- R11: A start byte that arrives in the middle of a frame abandons that frame and begins a new one. A byte marked both start and end forms a complete one-byte frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_sof | input | 1 | The current byte is the first byte of a frame |
| rx_valid | input | 1 | `rx_data` holds a byte |
| rx_eof | input | 1 | The current byte is the last byte of a frame |
| rx_data | input | 8 | Received byte |
| pat_mask | input | 32 | Byte selection mask for the window (bit 31 unused) |
| pat_cmd | input | 4 | Bit 0 enables the filter, bit 3 selects multicast, bits 2:1 are unused |
| pat_offset | input | 8 | Start of the window, as a byte index |
| pat_crc | input | 16 | Expected CRC-16 |
| wake_hit | output | 1 | One-cycle pulse when a wake-up frame is detected |

## Verification
The assertions assume that the start and end strobes only count when `rx_valid` is high, and that the configuration inputs stay stable from the start byte until the cycle after the end byte. The comparison reads them live, so a pulse is checked against the values from the end-byte cycle. The bench changes configuration only while the stream is idle. It always sends strobes together with valid bytes, and it ends every frame with at least two idle cycles, so that each pulse can be attributed to one frame.

// File: rtl/wpf_pkg.sv
package wpf_pkg;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_RECV
    } wpf_state_e;

    // One byte through a CRC-16, least significant bit first.
    function automatic logic [15:0] crc16_byte(
        input logic [15:0] crc_in,
        input logic [7:0]  data,
        input logic [15:0] poly
    );
        logic [15:0] c;
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            if (c[15] ^ data[b]) c = {c[14:0], 1'b0} ^ poly;
            else                 c = {c[14:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/wpf_byte_index.sv
module wpf_byte_index #(
    parameter int CNT_W   = 9,
    parameter int OFS_W   = 8,
    parameter int WIN     = 31,
    parameter int MIN_OFS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_en,
    input  logic             restart,
    input  logic [OFS_W-1:0] offset,
    input  logic [WIN-1:0]   mask,
    output logic [CNT_W-1:0] cnt_q,
    output logic             sel
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam int               REL_W   = $clog2(WIN + 1);

    logic [CNT_W-1:0] idx_cur;
    logic [CNT_W-1:0] eff_ofs;
    logic [CNT_W:0]   rel;
    logic             in_win;

    assign idx_cur = restart ? '0 : cnt_q;
    assign eff_ofs = (offset < OFS_W'(MIN_OFS)) ? CNT_W'(MIN_OFS) : CNT_W'(offset);
    assign rel     = {1'b0, idx_cur} - {1'b0, eff_ofs};
    assign in_win  = (idx_cur >= eff_ofs) && (rel < (CNT_W+1)'(WIN));
    assign sel     = in_win && mask[rel[REL_W-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (byte_en) cnt_q <= (idx_cur == CNT_MAX) ? CNT_MAX : idx_cur + 1'b1;
    end

endmodule

// File: rtl/wpf_crc16.sv
module wpf_crc16 #(
    parameter logic [15:0] POLY = 16'h8005,
    parameter logic [15:0] INIT = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_en,
    input  logic        restart,
    input  logic        sel,
    input  logic [7:0]  data,
    output logic [15:0] crc_next
);
    import wpf_pkg::*;

    logic [15:0] crc_q;
    logic [15:0] crc_base;

    assign crc_base = restart ? INIT : crc_q;
    assign crc_next = (byte_en && sel) ? crc16_byte(crc_base, data, POLY) : crc_base;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       crc_q <= INIT;
        else if (byte_en) crc_q <= crc_next;
    end

endmodule

// File: rtl/wpf_dest_class.sv
module wpf_dest_class (
    input  logic clk,
    input  logic rst_n,
    input  logic first_byte,
    input  logic group_bit,
    output logic mc_now
);
    logic mc_q;

    assign mc_now = first_byte ? group_bit : mc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          mc_q <= 1'b0;
        else if (first_byte) mc_q <= group_bit;
    end

endmodule

// File: rtl/wake_pattern_filter.sv
module wake_pattern_filter #(
    parameter int CNT_W   = 9,
    parameter int OFS_W   = 8,
    parameter int MASK_W  = 32,
    parameter int CRC_W   = 16,
    parameter int MIN_OFS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sof,
    input  logic              rx_valid,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    input  logic [MASK_W-1:0] pat_mask,
    input  logic [3:0]        pat_cmd,
    input  logic [OFS_W-1:0]  pat_offset,
    input  logic [CRC_W-1:0]  pat_crc,
    output logic              wake_hit
);
    import wpf_pkg::*;

    localparam int WIN = MASK_W - 1;

    wpf_state_e       state, state_nx;
    logic             accept, start_byte, frame_end, hit_d;
    logic             sel, mc_now;
    logic [CNT_W-1:0] cnt_w;
    logic [15:0]      crc_nx;
    logic             unused_cfg;

    assign unused_cfg = ^{pat_mask[MASK_W-1], pat_cmd[2:1]};

    assign accept     = rx_valid && (rx_sof || state == ST_RECV);
    assign start_byte = rx_valid && rx_sof;
    assign frame_end  = accept && rx_eof;

    wpf_byte_index #(
        .CNT_W(CNT_W), .OFS_W(OFS_W), .WIN(WIN), .MIN_OFS(MIN_OFS)
    ) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_en (accept),
        .restart (start_byte),
        .offset  (pat_offset),
        .mask    (pat_mask[WIN-1:0]),
        .cnt_q   (cnt_w),
        .sel     (sel)
    );

    wpf_crc16 #(.POLY(16'h8005), .INIT(16'hFFFF)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_en  (accept),
        .restart  (start_byte),
        .sel      (sel),
        .data     (rx_data),
        .crc_next (crc_nx)
    );

    wpf_dest_class u_class (
        .clk        (clk),
        .rst_n      (rst_n),
        .first_byte (start_byte),
        .group_bit  (rx_data[0]),
        .mc_now     (mc_now)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start_byte && !rx_eof) state_nx = ST_RECV;   // open
            ST_RECV: if (frame_end)             state_nx = ST_IDLE;   // close
            default:                            state_nx = ST_IDLE;
        endcase
    end

    assign hit_d = frame_end && pat_cmd[0] && (mc_now == pat_cmd[3])
                   && (crc_nx == pat_crc[15:0]);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_hit <= 1'b0;
        else        wake_hit <= hit_d;
    end

endmodule

// File: rtl/wpf_chk.sv
module wpf_chk #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             rx_sof,
    input logic             rx_eof,
    input logic [3:0]       pat_cmd,
    input logic [15:0]      pat_crc,
    input logic [15:0]      crc_nx,
    input logic             mc_now,
    input logic [CNT_W-1:0] cnt_w,
    input logic             wake_hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R8
    hit_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_hit |-> $past(rx_valid && rx_eof));

    // R5
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_hit |-> $past(pat_cmd[0]));

    // R7
    hit_needs_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_hit |-> $past(crc_nx == pat_crc));

    // R6
    hit_needs_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_hit |-> $past(mc_now == pat_cmd[3]));

    // R10
    count_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_w == CNT_MAX && !(rx_valid && rx_sof)) |=> cnt_w == CNT_MAX);

endmodule

bind wake_pattern_filter wpf_chk #(.CNT_W(CNT_W)) u_wpf_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_sof   (rx_sof),
    .rx_eof   (rx_eof),
    .pat_cmd  (pat_cmd),
    .pat_crc  (pat_crc),
    .crc_nx   (crc_nx),
    .mc_now   (mc_now),
    .cnt_w    (cnt_w),
    .wake_hit (wake_hit)
);

// File: tb/test_wake_pattern_filter.sv
module test_wake_pattern_filter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        rx_sof = 0, rx_valid = 0, rx_eof = 0;
    logic [7:0]  rx_data = 0;
    logic [31:0] pat_mask = 0;
    logic [3:0]  pat_cmd = 0;
    logic [7:0]  pat_offset = 12;
    logic [15:0] pat_crc = 0;
    logic        wake_hit;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [7:0] frm [0:799];

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_pattern_filter i_wake_pattern_filter (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid),
        .rx_eof(rx_eof), .rx_data(rx_data), .pat_mask(pat_mask),
        .pat_cmd(pat_cmd), .pat_offset(pat_offset), .pat_crc(pat_crc),
        .wake_hit(wake_hit)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference CRC over the selected window bytes of frm[0:len-1]
    function automatic logic [15:0] ref_crc(input int len, input int ofs,
                                            input logic [31:0] msk);
        logic [15:0] c = 16'hFFFF;
        int eff = (ofs < 12) ? 12 : ofs;
        for (int i = 0; i < len; i++) begin
            int r = i - eff;
            if (r >= 0 && r < 31 && msk[r]) begin
                for (int b = 0; b < 8; b++) begin
                    logic fb = c[15] ^ frm[i][b];
                    c = {c[14:0], 1'b0};
                    if (fb) c = c ^ 16'h8005;
                end
            end
        end
        return c;
    endfunction

    task automatic fill(input int len, input int seed, input logic [7:0] first);
        for (int i = 0; i < len; i++) frm[i] = 8'((i * 37 + seed * 11) ^ (i >> 3));
        frm[0] = first;
    endtask

    // Sends bytes 0..len-1; end strobe on the last when with_eof
    task automatic push(input int len, input bit with_eof, output int pulses);
        pulses = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (wake_hit) pulses++;
            rx_valid = 1; rx_sof = (i == 0); rx_eof = with_eof && (i == len - 1);
            rx_data = frm[i];
        end
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 0;
    endtask

    task automatic run_frame(input int len, input bit exp, input string req,
                             input string what);
        int pulses;
        bit got, after;
        push(len, 1, pulses);
        got = wake_hit;
        @(negedge clk);
        after = wake_hit;
        check(got == exp, req, what, got, exp);
        check(pulses == 0 && after == 0, "R8", {what, " pulse width"},
              pulses + after, 0);
    endtask

    task automatic t_reset();
        check(wake_hit == 0, "R8", "reset value", wake_hit, 0);
    endtask

    task automatic t_basic();
        fill(64, 1, 8'h02);
        pat_mask = 32'h0F0F_3A5C; pat_offset = 14; pat_cmd = 4'b0001;
        pat_crc = ref_crc(64, 14, pat_mask);
        run_frame(64, 1, "R1", "masked bytes hit");
        pat_mask = 32'h0F0F_3A5D;
        run_frame(64, 0, "R1", "extra mask bit changes CRC");
        pat_mask = 32'h0F0F_3A5C;
        frm[14 + 1] = ~frm[14 + 1];
        run_frame(64, 1, "R1", "unmasked byte ignored");
        frm[14 + 2] = ~frm[14 + 2];
        run_frame(64, 0, "R7", "masked byte altered");
    endtask

    task automatic t_restart_crc();
        fill(64, 1, 8'h02);
        pat_mask = 32'h7FFF_FFFF; pat_offset = 20; pat_cmd = 4'b0001;
        pat_crc = ref_crc(64, 20, pat_mask);
        run_frame(64, 1, "R3", "first frame");
        run_frame(64, 1, "R3", "same frame again, CRC restarted");
        pat_crc = pat_crc ^ 16'h0001;
        run_frame(64, 0, "R7", "CRC off by one bit");
    endtask

    task automatic t_enable();
        fill(50, 3, 8'h00);
        pat_mask = 32'h0000_FFFF; pat_offset = 12; pat_cmd = 4'b0000;
        pat_crc = ref_crc(50, 12, pat_mask);
        run_frame(50, 0, "R5", "disabled filter");
        pat_cmd = 4'b0001;
        run_frame(50, 1, "R5", "enabled filter");
    endtask

    task automatic t_class();
        fill(50, 4, 8'h01);
        pat_mask = 32'h00FF_00FF; pat_offset = 16; pat_cmd = 4'b0001;
        pat_crc = ref_crc(50, 16, pat_mask);
        run_frame(50, 0, "R6", "multicast frame, unicast programmed");
        pat_cmd = 4'b1001;
        run_frame(50, 1, "R6", "multicast frame, multicast programmed");
        pat_cmd = 4'b1111;
        run_frame(50, 1, "R6", "reserved command bits set");
        frm[0] = 8'hFE;
        run_frame(50, 0, "R6", "unicast frame, multicast programmed");
    endtask

    task automatic t_offset();
        fill(60, 5, 8'h00);
        pat_mask = 32'h0000_0FFF; pat_cmd = 4'b0001; pat_offset = 3;
        pat_crc = ref_crc(60, 12, pat_mask);
        run_frame(60, 1, "R4", "offset below 12 acts as 12");
        pat_offset = 0;
        run_frame(60, 1, "R4", "offset 0 acts as 12");
        frm[5] = ~frm[5];
        run_frame(60, 1, "R4", "address byte never checked");
    endtask

    task automatic t_bit31();
        fill(80, 6, 8'h00);
        pat_offset = 20; pat_cmd = 4'b0001; pat_mask = 32'h4000_0001;
        pat_crc = ref_crc(80, 20, pat_mask);
        pat_mask = 32'hC000_0001;
        run_frame(80, 1, "R2", "mask bit 31 set");
        frm[20 + 31] = ~frm[20 + 31];
        run_frame(80, 1, "R2", "32nd window byte altered");
    endtask

    task automatic t_short();
        fill(30, 7, 8'h00);
        pat_offset = 18; pat_cmd = 4'b0001; pat_mask = 32'h7FFF_FFFF;
        pat_crc = ref_crc(30, 18, pat_mask);
        run_frame(30, 1, "R9", "truncated window");
        pat_crc = ref_crc(30, 18, pat_mask) ^ 16'h8000;
        run_frame(30, 0, "R9", "truncated window wrong CRC");
    endtask

    task automatic t_long();
        fill(800, 8, 8'h00);
        pat_offset = 250; pat_cmd = 4'b0001; pat_mask = 32'h5555_5555;
        pat_crc = ref_crc(286, 250, pat_mask);
        run_frame(800, 1, "R10", "long frame, no wrap");
        for (int i = 512 + 250; i < 800; i++) frm[i] = ~frm[i];
        run_frame(800, 1, "R10", "bytes past counter range ignored");
    endtask

    task automatic t_restart_frame();
        int p;
        fill(40, 9, 8'h01);
        push(40, 0, p);
        fill(40, 10, 8'h00);
        pat_offset = 12; pat_cmd = 4'b0001; pat_mask = 32'h000F_FFFF;
        pat_crc = ref_crc(40, 12, pat_mask);
        run_frame(40, 1, "R11", "start mid-frame restarts");
        frm[0] = 8'h00;
        pat_mask = 32'h0; pat_crc = 16'hFFFF;
        run_frame(1, 1, "R11", "one-byte frame");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_restart_crc();
        t_enable();
        t_class();
        t_offset();
        t_bit31();
        t_short();
        t_long();
        t_restart_frame();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule